// File: doc/BRIEF.md
# Host-to-Core 32-bit Word Splitter

This block sits between a 32-bit host write port and a 24-bit core read port. Each accepted host word goes into a 32-bit holding register. Over the next two cycles the block moves the word into a receive FIFO as two separate core words. Each core word carries one 16-bit half of the host word in its two low bytes, and its top byte is zero. The low half of the host word always goes in before the high half. A core that reads two words in a row therefore gets bits 15:0 of the host word first and bits 31:16 second.

The host side has a write strobe, a data bus and a ready signal. A write takes effect only in a cycle where both the strobe and ready are high. Ready stays low while a half is still waiting in the holding register, and while the FIFO has fewer than two free entries.

The core side has a read strobe, a registered data output, a not-empty flag and a full flag. A read updates the data output at the clock edge where it is accepted. A read made while the FIFO is empty leaves everything as it was.

Top module: `hostWordSplitter`

## Requirements
- R1: After reset, hostReady is 1, coreNotEmpty is 0, fifoFull is 0 and coreData is 0.
- R2: For an accepted host word D, the first core word read is {8'h00, D[15:0]}.
- R3: For an accepted host word D, the core word read after R2's word is {8'h00, D[31:16]}.
- R4: Bits 23:16 of coreData are 0 at all times.
- R5: hostReady is 0 in each of the two cycles that follow an accepted host write, while the halves are being transferred.
- R6: hostReady is 0 whenever the FIFO holds more than DEPTH-2 entries. With DEPTH=4, 3 entries keep it low and 2 entries let it rise.
- R7: fifoFull is 1 exactly when the FIFO holds DEPTH entries. coreNotEmpty is 1 exactly when it holds at least one entry.
- R8: A core read while coreNotEmpty is 0 leaves coreData and both flags unchanged.
- R9: A host write strobe while hostReady is 0 is ignored and puts nothing into the FIFO.
- R10: If an accepted host write finds the FIFO empty, coreNotEmpty is still 0 one cycle after the accepting edge and is 1 two edges after it.
- R11: Core words come out in the order the host words were accepted, with the two halves of each word kept together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrite | input | 1 | Host write strobe |
| hostData | input | 32 | Host write data |
| hostReady | output | 1 | A host write is accepted in this cycle if hostWrite is also high |
| coreRead | input | 1 | Core read strobe |
| coreData | output | 24 | Last word popped from the FIFO |
| coreNotEmpty | output | 1 | FIFO holds at least one word |
| fifoFull | output | 1 | FIFO holds DEPTH words |

## Verification
The assertions check four things on every cycle: that the upper byte of coreData stays zero, that ready drops after each accepted write, that the full flag blocks ready and implies not-empty, and that an empty read leaves the output stable. They also check the two-edge delay from an accepted write to coreNotEmpty.

Some behaviour only the bench scenarios can show. These are the order of the two halves and the actual half values, the FIFO order across many host words, and the exact occupancy at which ready comes back. They also include proof that a write refused while ready is low leaves no trace in the FIFO.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef struct packed {
    logic loadHold;
    logic pushLo;
    logic pushHi;
  } splitStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PUSH_LO = 2'd1,
    ST_PUSH_HI = 2'd2
  } splitState_t;
endpackage

// File: rtl/hwsRxFifo.sv
module hwsRxFifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic pushOk, popOk;

  assign empty  = (count == '0);
  assign full   = (count == FULL_CNT);
  assign popOk  = pop && !empty;
  assign pushOk = push && !full;

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popOk) begin
        rdPtr  <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
        rdData <= mem[rdPtr];
      end
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hwsSplitDatapath.sv
module hwsSplitDatapath
  import hws_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int CORE_W = 24,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  splitStrobes_t     strobes,
  input  logic [HOST_W-1:0] hostData,
  input  logic              coreRead,
  output logic [CORE_W-1:0] coreData,
  output logic              coreNotEmpty,
  output logic              fifoFull,
  output logic              roomForTwo
);
  localparam int HALF_W = HOST_W / 2;
  localparam int PAD_W  = CORE_W - HALF_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(DEPTH - 2);

  logic [HOST_W-1:0] holdReg;
  logic [HALF_W-1:0] halfSel;
  logic [CORE_W-1:0] coreWord;
  logic [CNT_W-1:0]  fifoCount;
  logic              fifoEmpty;

  always_ff @(posedge clk) begin
    if (!rstN)                 holdReg <= '0;
    else if (strobes.loadHold) holdReg <= hostData;
  end

  assign halfSel = strobes.pushHi ? holdReg[HOST_W-1:HALF_W] : holdReg[HALF_W-1:0];

  generate
    if (PAD_W > 0) begin : g_pad
      assign coreWord = {{PAD_W{1'b0}}, halfSel};
    end else begin : g_trim
      assign coreWord = halfSel[CORE_W-1:0];
    end
  endgenerate

  hwsRxFifo #(.WIDTH(CORE_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobes.pushLo | strobes.pushHi),
    .pushData (coreWord),
    .pop      (coreRead),
    .rdData   (coreData),
    .count    (fifoCount),
    .empty    (fifoEmpty),
    .full     (fifoFull)
  );

  assign coreNotEmpty = !fifoEmpty;
  assign roomForTwo   = (fifoCount <= ROOM_LIMIT);
endmodule

// File: rtl/hwsSplitCtrl.sv
module hwsSplitCtrl
  import hws_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWrite,
  input  logic          roomForTwo,
  output logic          hostReady,
  output splitStrobes_t strobes
);
  splitState_t state, stateNext;

  assign hostReady = (state == ST_IDLE) && roomForTwo;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      ST_IDLE: begin
        if (hostWrite && hostReady) begin
          strobes.loadHold = 1'b1;
          stateNext        = ST_PUSH_LO;
        end
      end
      ST_PUSH_LO: begin
        strobes.pushLo = 1'b1;
        stateNext      = ST_PUSH_HI;
      end
      ST_PUSH_HI: begin
        strobes.pushHi = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/hostWordSplitter.sv
module hostWordSplitter
  import hws_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int CORE_W = 24,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrite,
  input  logic [HOST_W-1:0] hostData,
  output logic              hostReady,
  input  logic              coreRead,
  output logic [CORE_W-1:0] coreData,
  output logic              coreNotEmpty,
  output logic              fifoFull
);
  splitStrobes_t strobes;
  logic          roomForTwo;

  hwsSplitCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrite  (hostWrite),
    .roomForTwo (roomForTwo),
    .hostReady  (hostReady),
    .strobes    (strobes)
  );

  hwsSplitDatapath #(.HOST_W(HOST_W), .CORE_W(CORE_W), .DEPTH(DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .hostData     (hostData),
    .coreRead     (coreRead),
    .coreData     (coreData),
    .coreNotEmpty (coreNotEmpty),
    .fifoFull     (fifoFull),
    .roomForTwo   (roomForTwo)
  );
endmodule

// File: rtl/hostWordSplitterChecker.sv
module hostWordSplitterChecker #(
  parameter int CORE_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrite,
  input logic              hostReady,
  input logic              coreRead,
  input logic [CORE_W-1:0] coreData,
  input logic              coreNotEmpty,
  input logic              fifoFull
);
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    coreData[CORE_W-1:16] == '0);

  assert_busy_after_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrite && hostReady) |=> !hostReady);

  assert_full_blocks_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !hostReady);

  assert_full_implies_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> coreNotEmpty);

  assert_empty_read_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (coreRead && !coreNotEmpty) |=> $stable(coreData));

  assert_data_after_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrite && hostReady) |-> ##2 coreNotEmpty);
endmodule

bind hostWordSplitter hostWordSplitterChecker #(.CORE_W(CORE_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .hostWrite    (hostWrite),
  .hostReady    (hostReady),
  .coreRead     (coreRead),
  .coreData     (coreData),
  .coreNotEmpty (coreNotEmpty),
  .fifoFull     (fifoFull)
);

// File: tb/hostWordSplitter_bench.sv
module hostWordSplitter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostWrite;
  logic [31:0] hostData;
  logic        hostReady;
  logic        coreRead;
  logic [23:0] coreData;
  logic        coreNotEmpty;
  logic        fifoFull;

  int testsRun = 0;
  int testsFailed = 0;
  bit doneFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostWordSplitter u_hostWordSplitter (
    .clk(clk), .rstN(rstN), .hostWrite(hostWrite), .hostData(hostData),
    .hostReady(hostReady), .coreRead(coreRead), .coreData(coreData),
    .coreNotEmpty(coreNotEmpty), .fifoFull(fifoFull)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  function automatic logic [31:0] loWord(input logic [31:0] d);
    return {16'h0000, d[15:0]};
  endfunction
  function automatic logic [31:0] hiWord(input logic [31:0] d);
    return {16'h0000, d[31:16]};
  endfunction

  // Called at a negedge; returns at a negedge after the accepting edge.
  task automatic writeHost(input logic [31:0] d);
    while (!hostReady) @(negedge clk);
    hostWrite = 1'b1;
    hostData  = d;
    @(posedge clk);
    @(negedge clk);
    hostWrite = 1'b0;
  endtask

  task automatic readCore(output logic [23:0] v);
    coreRead = 1'b1;
    @(posedge clk);
    @(negedge clk);
    coreRead = 1'b0;
    v = coreData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [23:0] v;
    logic [31:0] wA, wB;
    rstN = 1'b0; hostWrite = 1'b0; hostData = '0; coreRead = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 hostReady", 32'(hostReady), 32'd1);
    chk("R1 coreNotEmpty", 32'(coreNotEmpty), 32'd0);
    chk("R1 fifoFull", 32'(fifoFull), 32'd0);
    chk("R1 coreData", 32'(coreData), 32'd0);

    // R10 / R5 timeline of one write into an empty FIFO
    wA = 32'hA1B2C3D4;
    writeHost(wA);
    chk("R5 ready low cycle 1", 32'(hostReady), 32'd0);
    chk("R10 empty one cycle after", 32'(coreNotEmpty), 32'd0);
    @(negedge clk);
    chk("R5 ready low cycle 2", 32'(hostReady), 32'd0);
    chk("R10 notEmpty two edges after", 32'(coreNotEmpty), 32'd1);
    @(negedge clk);
    chk("R5 ready back", 32'(hostReady), 32'd1);
    readCore(v); chk("R2 low half first", 32'(v), loWord(wA));
    readCore(v); chk("R3 high half second", 32'(v), hiWord(wA));
    chk("R4 upper byte zero", 32'(v[23:16]), 32'd0);

    // R8 read while empty
    chk("R8 empty before", 32'(coreNotEmpty), 32'd0);
    readCore(v);
    chk("R8 data unchanged", 32'(v), hiWord(wA));
    chk("R8 notEmpty unchanged", 32'(coreNotEmpty), 32'd0);
    chk("R8 full unchanged", 32'(fifoFull), 32'd0);

    // R2 R3 R11 sweep: walking ones then mixed patterns, two words per batch
    for (int w = 0; w < 48; w += 2) begin
      wA = (w < 32) ? (32'd1 << w) : (32'(w) * 32'h9E3779B9);
      wB = (w + 1 < 32) ? ~(32'd1 << (w + 1)) : (32'(w + 1) * 32'h7F4A7C15) ^ 32'h5A5A0F0F;
      writeHost(wA);
      writeHost(wB);
      @(negedge clk); @(negedge clk);
      readCore(v); chk("R2 sweep lo A", 32'(v), loWord(wA));
      readCore(v); chk("R3 sweep hi A", 32'(v), hiWord(wA));
      readCore(v); chk("R11 sweep lo B", 32'(v), loWord(wB));
      readCore(v); chk("R11 sweep hi B", 32'(v), hiWord(wB));
      chk("R7 drained", 32'(coreNotEmpty), 32'd0);
    end

    // R6 R7 R9 full FIFO and refused writes
    wA = 32'h13572468; wB = 32'hFEDC0123;
    writeHost(wA);
    writeHost(wB);
    @(negedge clk); @(negedge clk);
    chk("R7 full at DEPTH", 32'(fifoFull), 32'd1);
    chk("R6 ready low when full", 32'(hostReady), 32'd0);
    hostWrite = 1'b1; hostData = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    hostWrite = 1'b0;
    chk("R9 still full", 32'(fifoFull), 32'd1);
    readCore(v); chk("R11 lo A after full", 32'(v), loWord(wA));
    chk("R6 ready low at 3 entries", 32'(hostReady), 32'd0);
    chk("R7 not full at 3", 32'(fifoFull), 32'd0);
    readCore(v); chk("R11 hi A after full", 32'(v), hiWord(wA));
    chk("R6 ready high at 2 entries", 32'(hostReady), 32'd1);
    readCore(v); chk("R11 lo B", 32'(v), loWord(wB));
    readCore(v); chk("R11 hi B", 32'(v), hiWord(wB));
    chk("R9 refused write left nothing", 32'(coreNotEmpty), 32'd0);
    readCore(v); chk("R8 empty read keeps data", 32'(v), hiWord(wB));

    finishRun();
  end
endmodule